// File: doc/BRIEF.md
# SMBus Indexed-Block Configuration Target

This block is an SMBus target that lets a host read and program a small byte-wide configuration store. It receives an oversampled SCL and SDA and decodes start, repeated start and stop conditions. SDA is driven only by pulling the line low through an output-enable. Every transfer begins with a starting index. A write then carries a byte count and that many data bytes. A read is issued after a repeated start. The target first returns the value of its count register and then streams bytes from the index upward.

The 7-bit target address is one of two fixed values. A strap input selects it, and the strap is captured once, when the power-good input first goes high. The store holds read/write control bytes, a count register, two read-only identification bytes and reserved holes. All bytes are presented on one flat parallel bus so that the rest of the chip can use them.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges address byte 1101000x when the latched strap is 0 and 1101010x when it is 1. It acknowledges no other address, and after a mismatch it ignores every bit until the next start condition.
- R2: The strap is captured only on the first rising edge of `pwr_good`. Later strap changes and later power-good pulses have no effect. Before that first edge the target acknowledges nothing.
- R3: A block write (start, address with R/W=0, index N, count X, X data bytes, stop) stores the data bytes at locations N to N+X-1, and the target acknowledges every byte.
- R4: Data bytes sent beyond the count X are acknowledged and discarded.
- R5: A block read (start, address with R/W=0, index N, repeated start, address with R/W=1) returns the count register byte first. It then returns the bytes at N, N+1 and onward for as long as the host acknowledges. A not-acknowledge ends the read.
- R6: Location 7 is the read count register. Only bits 4:0 are stored, bits 7:5 read 0, and the reset value is 8.
- R7: Location 5 always reads 0x01 (revision 0 in bits 7:4, vendor 1 in bits 3:0). Location 6 always reads 0x08 (type 00 in bits 7:6, device 001000 in bits 5:0). Writes to both are acknowledged and discarded.
- R8: Locations 4, 8, 9 and 17, and every index at or above the store size, read 0. Writes to them are discarded.
- R9: A stop or a start in the middle of a transfer abandons it. A partly received data byte is not written, and a start always begins a fresh address phase.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, every read/write location is 0x00 and SDA is released.
- R12: `cfg_flat[8*i+7:8*i]` always shows the current content of location i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pwr_good | input | 1 | Power-good; its first rise captures the strap |
| addr_strap | input | 1 | Address select strap |
| cfg_flat | output | NREG*8 | All locations, location i in bits 8i+7:8i |

## Verification
The corner cases under test are these:
- Address phases sent before power-good and after the strap has moved. A target that re-latched the strap would acknowledge the wrong address.
- Data bytes beyond the count. A design that ignored the count would overwrite neighbours.
- Writes that run across the identification, count and reserved locations. A faulty store would let their values drift or read back non-zero holes.
- Transfers cut short by a stop in the middle of a byte and by an unexpected repeated start. Wrong recovery would write a half byte or stay deaf on the next transfer.
- Reads whose length the count register sets, including counts of 0, and reads that run past the end of the store. A wrong pointer would return shifted data, and a wrong count byte would show up as a mismatch in the first returned byte.

// File: rtl/smb_cfg_pkg.sv
// Shared types and the location map of the SMBus configuration target.
// Assumes the store has more than 17 locations so every fixed location exists.
package smb_cfg_pkg;

    localparam int IDXW     = 8;   // width of the index byte
    localparam int CNT_LOC  = 7;   // location of the read count register
    localparam int CNT_BITS = 5;   // stored bits of the count register
    localparam logic [CNT_BITS-1:0] CNT_RESET = 5'd8;

    localparam logic [3:0] REV_CODE  = 4'h0;
    localparam logic [3:0] VEND_CODE = 4'h1;
    localparam logic [1:0] TYPE_CODE = 2'b00;
    localparam logic [5:0] DEV_CODE  = 6'h08;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK, PH_IGNORE
    } phase_t;

    typedef enum logic [1:0] {
        SG_ADDR, SG_INDEX, SG_COUNT, SG_DATA
    } stage_t;

    typedef enum logic [1:0] {
        LOC_RW, LOC_RO, LOC_RSV, LOC_CNT
    } loc_kind_t;

    // Classifies a location of the store.
    function automatic loc_kind_t loc_kind(input int idx);
        if (idx == 4 || idx == 8 || idx == 9 || idx == 17) return LOC_RSV;
        if (idx == 5 || idx == 6) return LOC_RO;
        if (idx == CNT_LOC) return LOC_CNT;
        return LOC_RW;
    endfunction

    // Fixed content of the read-only identification locations.
    function automatic logic [7:0] ro_value(input int idx);
        if (idx == 5) return {REV_CODE, VEND_CODE};
        if (idx == 6) return {TYPE_CODE, DEV_CODE};
        return 8'h00;
    endfunction

endpackage

// File: rtl/smb_line_cond.sv
// Synchronises SCL and SDA and flags clock edges, start and stop conditions.
// Assumes SCL and SDA stay stable for several clk cycles between changes.
module smb_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_d, sda_d, scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s      = scl_pipe[SYNC_STAGES-1];
    assign sda_s      = sda_pipe[SYNC_STAGES-1];
    assign scl_rise   = scl_s & ~scl_d;
    assign scl_fall   = ~scl_s & scl_d;
    assign start_seen = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_seen  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_addr_strap.sv
// Captures the address strap on the first rise of power-good and holds it.
// Assumes pwr_good is already synchronous to clk.
module smb_addr_strap #(
    parameter logic [6:0] ADDR_LO = 7'h68,
    parameter logic [6:0] ADDR_HI = 7'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       addr_strap,
    output logic       armed,
    output logic [6:0] own_addr
);
    logic pg_q, strap_q;

    // One-time capture of the strap at the first power-good rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q    <= 1'b0;
            armed   <= 1'b0;
            strap_q <= 1'b0;
        end else begin
            pg_q <= pwr_good;
            if (pwr_good && !pg_q && !armed) begin
                armed   <= 1'b1;
                strap_q <= addr_strap;
            end
        end
    end

    assign own_addr = strap_q ? ADDR_HI : ADDR_LO;
endmodule

// File: rtl/smb_cfg_regs.sv
// Byte-wide configuration store: read/write, count, read-only and reserved locations.
// Assumes one write per cycle; an index outside the store reads 0.
module smb_cfg_regs
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_flat
);
    logic [7:0] loc_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_loc
        localparam loc_kind_t KIND = loc_kind(g);
        if (KIND == LOC_RW) begin : g_rw
            logic [7:0] q;
            // Plain read/write byte.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 8'h00;
                else if (wr_en && wr_idx == IDXW'(g)) q <= wr_data;
            end
            assign loc_q[g] = q;
        end else if (KIND == LOC_CNT) begin : g_cnt
            logic [CNT_BITS-1:0] q;
            // Read count register, only the low bits are stored.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= CNT_RESET;
                else if (wr_en && wr_idx == IDXW'(g)) q <= wr_data[CNT_BITS-1:0];
            end
            assign loc_q[g] = {{(8-CNT_BITS){1'b0}}, q};
        end else if (KIND == LOC_RO) begin : g_ro
            assign loc_q[g] = ro_value(g);
        end else begin : g_rsv
            assign loc_q[g] = 8'h00;
        end
        assign cfg_flat[g*8 +: 8] = loc_q[g];
    end

    // Read mux; indexes beyond the store return 0.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IDXW'(i)) rd_data = loc_q[i];
        end
    end
endmodule

// File: rtl/smb_xfer_ctrl.sv
// Bit and byte sequencer for indexed block writes and reads.
// Assumes conditions from smb_line_cond; drives SDA only after an SCL fall.
module smb_xfer_ctrl
    import smb_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_seen,
    input  logic            stop_seen,
    input  logic            armed,
    input  logic [6:0]      own_addr,
    input  logic [7:0]      cnt_byte,
    input  logic [7:0]      rd_data,
    output logic [IDXW-1:0] rd_idx,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_oe
);
    phase_t          phase;
    stage_t          stage;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [IDXW-1:0] ptr;
    logic [7:0]      left;
    logic            rd_mode;
    logic            host_ack;

    assign rd_idx = ptr;

    // Transfer state machine: shifts bits, acknowledges bytes, streams read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            stage    <= SG_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            left     <= '0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_seen) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else if (start_seen) begin
                phase   <= armed ? PH_RX : PH_IGNORE;
                stage   <= SG_ADDR;
                bitcnt  <= '0;
                rd_mode <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            phase  <= PH_RX_ACK;
                            sda_oe <= 1'b1;
                            unique case (stage)
                                SG_ADDR: begin
                                    if (shreg[7:1] == own_addr) begin
                                        rd_mode <= shreg[0];
                                        stage   <= SG_INDEX;
                                    end else begin
                                        phase  <= PH_IGNORE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                SG_INDEX: begin
                                    ptr   <= shreg;
                                    stage <= SG_COUNT;
                                end
                                SG_COUNT: begin
                                    left  <= shreg;
                                    stage <= SG_DATA;
                                end
                                SG_DATA: begin
                                    if (left != 8'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr + 8'd1;
                                        left    <= left - 8'd1;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                phase  <= PH_TX;
                                shreg  <= cnt_byte;
                                sda_oe <= ~cnt_byte[7];
                                bitcnt <= '0;
                            end else begin
                                phase  <= PH_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_TX_ACK;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + 8'd1;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                phase  <= PH_TX;
                            end else begin
                                phase <= PH_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_target.sv
// Top of the SMBus configuration target: line conditioning, strap capture,
// transfer sequencer and configuration store. Assumes NREG > 17.
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter int NREG        = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pwr_good,
    input  logic              addr_strap,
    output logic [NREG*8-1:0] cfg_flat
);
    logic            sda_s, scl_rise, scl_fall, start_seen, stop_seen;
    logic            armed;
    logic [6:0]      own_addr;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [7:0]      wr_data, rd_data;

    smb_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    smb_addr_strap u_strap (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_strap(addr_strap),
        .armed(armed), .own_addr(own_addr)
    );

    smb_xfer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_seen(start_seen), .stop_seen(stop_seen),
        .armed(armed), .own_addr(own_addr),
        .cnt_byte(cfg_flat[CNT_LOC*8 +: 8]), .rd_data(rd_data),
        .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe)
    );

    smb_cfg_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cfg_flat(cfg_flat)
    );
endmodule

// File: rtl/smb_cfg_target_chk.sv
// Checker bound to smb_cfg_target; observes ports only.
module smb_cfg_target_chk
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              pwr_good,
    input logic [NREG*8-1:0] cfg_flat
);
    logic              pg_prev, pg_seen;
    logic [NREG*8-1:0] cfg_prev;
    logic [NREG-1:0]   byte_moved;

    // Tracks the first power-good rise and the previous store image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_prev <= 1'b0;
            pg_seen <= 1'b0;
        end else begin
            pg_prev <= pwr_good;
            if (pwr_good && !pg_prev) pg_seen <= 1'b1;
        end
        cfg_prev <= cfg_flat;
    end

    // Marks which locations changed since the last cycle.
    always_comb begin
        for (int i = 0; i < NREG; i++)
            byte_moved[i] = (cfg_flat[i*8 +: 8] != cfg_prev[i*8 +: 8]);
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R10

    AST_QUIET_BEFORE_PG: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_seen |-> !sda_oe); // R2

    AST_ID_BYTES_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flat[5*8 +: 8] == {REV_CODE, VEND_CODE} &&
        cfg_flat[6*8 +: 8] == {TYPE_CODE, DEV_CODE}); // R7

    AST_CNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flat[CNT_LOC*8+5 +: 3] == 3'b000); // R6

    AST_ONE_BYTE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(byte_moved) <= 1); // R3

    if (NREG > 17) begin : g_rsv
        AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[4*8 +: 8] == 8'h00 && cfg_flat[8*8 +: 8] == 8'h00 &&
            cfg_flat[9*8 +: 8] == 8'h00 && cfg_flat[17*8 +: 8] == 8'h00); // R8
    end
endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .pwr_good(pwr_good), .cfg_flat(cfg_flat)
);

// File: tb/test_smb_cfg_target.sv
module test_smb_cfg_target;
    localparam int NREG = 20;
    localparam int Q    = 10;
    localparam logic [6:0] A_LO = 7'h68;
    localparam logic [6:0] A_HI = 7'h6A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hscl = 1'b1, hsda = 1'b1;
    logic pwr_good = 1'b0, addr_strap = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_flat;
    wire  sda_line = hsda & ~sda_oe;

    always #2 clk = ~clk;

    smb_cfg_target #(.NREG(NREG)) i_smb_cfg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(hscl), .sda_i(sda_line),
        .sda_oe(sda_oe), .pwr_good(pwr_good), .addr_strap(addr_strap),
        .cfg_flat(cfg_flat)
    );

    int n_chk = 0, n_err = 0;
    logic [7:0] mdl [NREG];
    logic [7:0] wb [64];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_hole(input int i);
        return (i == 4 || i == 8 || i == 9 || i == 17 || i >= NREG);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        if (is_hole(int'(idx))) return 8'h00;
        return mdl[idx];
    endfunction

    function automatic void model_write(input logic [7:0] idx, input logic [7:0] v);
        int i = int'(idx);
        if (is_hole(i) || i == 5 || i == 6) return;
        if (i == 7) mdl[i] = v & 8'h1F;
        else mdl[i] = v;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (hscl) begin
            hsda = 1'b0; idle(Q); hscl = 1'b0; idle(Q);
        end else begin
            hsda = 1'b1; idle(Q); hscl = 1'b1; idle(Q);
            hsda = 1'b0; idle(Q); hscl = 1'b0; idle(Q);
        end
    endtask

    task automatic bus_stop();
        hsda = 1'b0; idle(Q); hscl = 1'b1; idle(Q); hsda = 1'b1; idle(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            hsda = b[i]; idle(Q); hscl = 1'b1; idle(Q); hscl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        hsda = 1'b1; idle(Q); hscl = 1'b1; idle(Q/2);
        acked = ~sda_line;
        idle(Q/2); hscl = 1'b0;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            idle(Q); hscl = 1'b1; idle(Q/2);
            b[i] = sda_line;
            idle(Q/2); hscl = 1'b0;
        end
        hsda = ~ack_it; idle(Q); hscl = 1'b1; idle(Q); hscl = 1'b0; hsda = 1'b1;
    endtask

    // Block write of n bytes from wb with declared count cnt.
    task automatic do_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                            input int n, input string req);
        logic ak;
        bus_start();
        send_byte({a, 1'b0}, ak); check(req, ak, 1, "address ack");
        send_byte(idx, ak);       check(req, ak, 1, "index ack");
        send_byte(cnt, ak);       check(req, ak, 1, "count ack");
        for (int i = 0; i < n; i++) begin
            send_byte(wb[i], ak); check(req, ak, 1, "data ack");
            if (i < int'(cnt)) model_write(idx + 8'(i), wb[i]);
        end
        bus_stop();
        idle(4);
    endtask

    // Block read: count byte, then as many bytes as the count register says.
    task automatic do_read(input logic [6:0] a, input logic [7:0] idx, input string req);
        logic ak;
        logic [7:0] b;
        int nd = int'(mdl[7] & 8'h1F);
        bus_start();
        send_byte({a, 1'b0}, ak); check(req, ak, 1, "address ack");
        send_byte(idx, ak);       check(req, ak, 1, "index ack");
        bus_start();
        send_byte({a, 1'b1}, ak); check(req, ak, 1, "read address ack");
        recv_byte(nd > 0, b);     check("R5", b, mdl[7] & 8'h1F, "count byte");
        for (int i = 0; i < nd; i++) begin
            recv_byte(i < nd - 1, b);
            check(req, b, exp_read(idx + 8'(i)), $sformatf("read byte at %0d", idx + 8'(i)));
        end
        bus_stop();
        idle(4);
    endtask

    task automatic check_image(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, cfg_flat[i*8 +: 8], exp_read(8'(i)), $sformatf("cfg_flat location %0d", i));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic ak;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        mdl[5] = 8'h01; mdl[6] = 8'h08; mdl[7] = 8'h08;

        idle(6); rst_n = 1'b1; idle(4);
        // R11 reset state, R6 count reset, R7 ID bytes, R12 image
        check("R11", sda_oe, 0, "SDA released after reset");
        check_image("R11");

        // R2: nothing is acknowledged before power-good
        bus_start(); send_byte({A_LO, 1'b0}, ak); check("R2", ak, 0, "ack before power-good");
        bus_stop(); idle(4);

        // R2: strap captured at the first rise only
        addr_strap = 1'b1; pwr_good = 1'b1; idle(6);
        addr_strap = 1'b0; pwr_good = 1'b0; idle(6);
        pwr_good = 1'b1; idle(6);

        // R1: other address not acknowledged, bus then ignored until start
        bus_start(); send_byte({A_LO, 1'b0}, ak); check("R1", ak, 0, "ack of unselected address");
        send_byte({A_HI, 1'b0}, ak); check("R1", ak, 0, "ack without new start");
        bus_stop(); idle(4);

        // R3: basic block write
        wb[0] = 8'hAA; wb[1] = 8'h55; wb[2] = 8'hC3;
        do_write(A_HI, 8'd0, 8'd3, 3, "R3");
        check_image("R3");

        // R4: bytes beyond the count are discarded
        wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
        do_write(A_HI, 8'd10, 8'd2, 4, "R4");
        check_image("R4");

        // R7, R8, R6: write across reserved, ID and count locations
        wb[0] = 8'hFF; wb[1] = 8'hFF; wb[2] = 8'hFF; wb[3] = 8'hE3;
        do_write(A_HI, 8'd4, 8'd4, 4, "R7");
        check("R6", cfg_flat[7*8 +: 8], 8'h03, "count keeps low bits only");
        check_image("R8");

        // R5: read back with count 3
        do_read(A_HI, 8'd0, "R5");

        // R8: read across a hole and past the store end, count 5
        wb[0] = 8'h05;
        do_write(A_HI, 8'd7, 8'd1, 1, "R6");
        do_read(A_HI, 8'd16, "R8");

        // R9: stop in the middle of a data byte
        bus_start();
        send_byte({A_HI, 1'b0}, ak); send_byte(8'd11, ak); send_byte(8'd3, ak);
        send_byte(8'h77, ak); check("R9", ak, 1, "first data ack");
        model_write(8'd11, 8'h77);
        send_bits(8'hF0, 4);
        bus_stop(); idle(4);
        check_image("R9");

        // R9: unexpected repeated start, then a fresh write
        bus_start();
        send_byte({A_HI, 1'b0}, ak); send_byte(8'd14, ak); send_byte(8'd2, ak);
        send_byte(8'h99, ak); model_write(8'd14, 8'h99);
        bus_start();
        send_byte({A_HI, 1'b0}, ak); check("R9", ak, 1, "address after restart");
        send_byte(8'd18, ak); send_byte(8'd1, ak);
        send_byte(8'h42, ak); model_write(8'd18, 8'h42);
        bus_stop(); idle(4);
        check_image("R9");

        // Random block writes with periodic reads (R3, R5, R12)
        for (int it = 0; it < 24; it++) begin
            logic [7:0] idx, cnt;
            int n;
            idx = 8'($urandom_range(0, 21));
            cnt = 8'($urandom_range(1, 4));
            n   = int'(cnt) + (($urandom_range(0, 3) == 0) ? 1 : 0);
            for (int k = 0; k < n; k++) wb[k] = 8'($urandom);
            do_write(A_HI, idx, cnt, n, "R3");
            check_image("R12");
            if (it % 4 == 3) begin
                wb[0] = 8'($urandom_range(0, 6));
                do_write(A_HI, 8'd7, 8'd1, 1, "R6");
                do_read(A_HI, 8'($urandom_range(0, 19)), "R5");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule